// File: doc/BRIEF.md
# Local Bus Wait-State Arbiter

This block drives the ready line of a processor's local bus. Each bus cycle starts when the address latch enable falls. In that cycle the block looks at the decoded access target, the read/write direction, and the state of the shared resources. From these it decides whether the processor must stretch the cycle. The ready line is pulled low combinationally in that same cycle, so the processor's sample in its second bus state already sees the request to wait. Each extra cycle that ready stays low is one whole wait state.

The block knows four reasons to wait, listed here by priority for dynamic RAM:

- A refresh is in progress. The wait ends one clock after the refresh-done strobe.
- Another bus master owns the shared RAM. The wait ends one clock after the RAM grant.
- The access is a dynamic RAM write. It takes a fixed number of wait states.
- The block is in master mode and the access goes off-board. The wait lasts until the system bus acknowledges. If no acknowledge arrives within a timeout, the wait is abandoned and an error flag is raised.

PROM, on-board I/O and static RAM accesses never wait. Ready and the error flag are plain level signals. The block has no valid/ready stream interface, so no back-pressure rules apply.

Top module: `wsa_ready_gen`

## Requirements
- R1: Target codes 0 (PROM), 1 (on-board I/O) and 2 (static RAM) never pull ready low. Off-board targets 4 (memory) and 5 (I/O) also never pull ready low when master mode is off.
- R2: A dynamic RAM access (target 3) that starts while refresh is busy holds ready low. Ready is released on the clock after refresh-done is seen in a wait cycle.
- R3: A dynamic RAM access that starts while another master is active on the RAM, with no refresh busy, holds ready low. Ready is released on the clock after the RAM grant is seen in a wait cycle.
- R4: With master mode on, an off-board access holds ready low until the clock after bus acknowledge is seen in a wait cycle.
- R5: A dynamic RAM write with neither refresh nor another master active holds ready low for exactly WR_WAITS cycles, counting the cycle in which the latch enable falls.
- R6: Conditions are sampled only in the cycle in which the latch enable falls (high on the previous clock, low now). When a wait is needed, ready is already low in that cycle. Release strobes that arrive outside a wait are ignored.
- R7: If an off-board wait sees no acknowledge for TIMEOUT_CYC wait cycles, ready returns high on the next cycle and the error flag is set. In that case ready is low TIMEOUT_CYC+1 cycles in total. The flag clears from the cycle after the next access starts.
- R8: If the acknowledge arrives in the last timeout cycle, the acknowledge wins and the error flag stays low.
- R9: Refresh outranks the other master. A dynamic RAM access with both conditions active waits only for refresh-done, and a grant during that wait has no effect. A dynamic RAM write delayed by refresh or another master adds no further write wait states.
- R10: While reset is asserted, ready is high and the error flag is low, even in the middle of a wait.
- R11: Unused target codes 6 and 7 never pull ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale_i | input | 1 | Address latch enable; its falling edge starts a bus cycle |
| tgt_i | input | 3 | Decoded access target code |
| wr_i | input | 1 | High for a write access |
| refresh_busy_i | input | 1 | RAM refresh in progress |
| refresh_done_i | input | 1 | Refresh completion strobe |
| peer_active_i | input | 1 | Another master is using the shared RAM |
| ram_grant_i | input | 1 | Shared RAM handed to the processor |
| master_mode_i | input | 1 | Board is operating as system bus master |
| bus_ack_i | input | 1 | System bus transfer acknowledge |
| ready_o | output | 1 | Processor ready; low inserts wait states |
| timeout_err_o | output | 1 | Off-board acknowledge timed out |

## Verification
The acknowledge and the timeout can both fall on the last cycle of an off-board wait. The bench provokes this by pulsing the acknowledge exactly TIMEOUT_CYC cycles into the wait. It expects TIMEOUT_CYC+1 low cycles and a clear error flag, and compares this with acknowledges one cycle later, which must produce the error. A second overlap is refresh-done and the RAM grant arriving in different cycles of one wait; only the refresh strobe may end it. Random accesses mix all targets, strobes and delays, and a reference function predicts both the low-cycle count and the flag.

// File: rtl/wsa_pkg.sv
package wsa_pkg;
  typedef enum logic [2:0] {
    TGT_PROM   = 3'd0,
    TGT_LIO    = 3'd1,
    TGT_SRAM   = 3'd2,
    TGT_DRAM   = 3'd3,
    TGT_OFFMEM = 3'd4,
    TGT_OFFIO  = 3'd5,
    TGT_RSV6   = 3'd6,
    TGT_RSV7   = 3'd7
  } tgt_e;

  typedef enum logic [2:0] {
    RSN_NONE,
    RSN_REFRESH,
    RSN_PEER,
    RSN_WRITE,
    RSN_BUS
  } reason_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REF,
    ST_PEER,
    ST_WR,
    ST_BUS
  } st_e;
endpackage

// File: rtl/wsa_decode.sv
module wsa_decode
  import wsa_pkg::*;
(
  input  tgt_e    tgt_i,
  input  logic    wr_i,
  input  logic    refresh_busy_i,
  input  logic    peer_active_i,
  input  logic    master_mode_i,
  output reason_e reason_o
);
  always_comb begin
    reason_o = RSN_NONE;
    unique case (tgt_i)
      TGT_DRAM: begin
        if (refresh_busy_i)     reason_o = RSN_REFRESH;
        else if (peer_active_i) reason_o = RSN_PEER;
        else if (wr_i)          reason_o = RSN_WRITE;
      end
      TGT_OFFMEM, TGT_OFFIO: begin
        if (master_mode_i) reason_o = RSN_BUS;
      end
      default: reason_o = RSN_NONE;
    endcase
  end
endmodule

// File: rtl/wsa_timer.sv
module wsa_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/wsa_ctrl.sv
module wsa_ctrl
  import wsa_pkg::*;
#(
  parameter int WR_WAITS    = 1,
  parameter int TIMEOUT_CYC = 16,
  parameter int CNT_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  reason_e          reason_i,
  input  logic             refresh_done_i,
  input  logic             ram_grant_i,
  input  logic             bus_ack_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             clr_o,
  output logic             en_o,
  output logic             busy_o,
  output logic             err_o
);
  localparam bit             MULTI_WR = (WR_WAITS > 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(MULTI_WR ? WR_WAITS - 2 : 0);
  localparam logic [CNT_W-1:0] TO_LAST = CNT_W'(TIMEOUT_CYC - 1);

  st_e  st, st_nxt;
  logic err_set;

  always_comb begin
    st_nxt  = st;
    clr_o   = 1'b0;
    en_o    = 1'b0;
    err_set = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (start_i) begin
          clr_o = 1'b1;
          unique case (reason_i)
            RSN_REFRESH: st_nxt = ST_REF;
            RSN_PEER:    st_nxt = ST_PEER;
            RSN_BUS:     st_nxt = ST_BUS;
            RSN_WRITE:   st_nxt = MULTI_WR ? ST_WR : ST_IDLE;
            default:     st_nxt = ST_IDLE;
          endcase
        end
      end
      ST_REF:  if (refresh_done_i) st_nxt = ST_IDLE;
      ST_PEER: if (ram_grant_i)    st_nxt = ST_IDLE;
      ST_WR: begin
        en_o = 1'b1;
        if (cnt_i == WR_LAST) st_nxt = ST_IDLE;
      end
      ST_BUS: begin
        en_o = 1'b1;
        if (bus_ack_i) st_nxt = ST_IDLE;
        else if (cnt_i == TO_LAST) begin
          st_nxt  = ST_IDLE;
          err_set = 1'b1;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      err_o <= 1'b0;
    end else begin
      st <= st_nxt;
      if (err_set)                     err_o <= 1'b1;
      else if (st == ST_IDLE && start_i) err_o <= 1'b0;
    end
  end

  assign busy_o = (st != ST_IDLE);

  AST_REFRESH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REF && refresh_done_i) |=> !busy_o); // R2
  AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PEER && ram_grant_i) |=> !busy_o); // R3
  AST_TIMEOUT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BUS && !bus_ack_i && cnt_i == TO_LAST) |=> (err_o && !busy_o)); // R7
  AST_ACK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BUS && bus_ack_i) |=> !err_o); // R8
  AST_BUS_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BUS) |-> (cnt_i <= TO_LAST)); // R7
endmodule

// File: rtl/wsa_ready_gen.sv
module wsa_ready_gen
  import wsa_pkg::*;
#(
  parameter int WR_WAITS    = 1,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ale_i,
  input  logic [2:0] tgt_i,
  input  logic       wr_i,
  input  logic       refresh_busy_i,
  input  logic       refresh_done_i,
  input  logic       peer_active_i,
  input  logic       ram_grant_i,
  input  logic       master_mode_i,
  input  logic       bus_ack_i,
  output logic       ready_o,
  output logic       timeout_err_o
);
  localparam int MAXV  = (WR_WAITS > TIMEOUT_CYC) ? WR_WAITS : TIMEOUT_CYC;
  localparam int CNT_W = $clog2(MAXV + 1);

  logic             ale_q, start, busy, clr, en;
  logic [CNT_W-1:0] cnt;
  reason_e          reason;
  tgt_e             tgt;

  assign tgt = tgt_e'(tgt_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ale_q <= 1'b0;
    else        ale_q <= ale_i;
  end
  assign start = ale_q & ~ale_i;

  wsa_decode u_dec (
    .tgt_i          (tgt),
    .wr_i           (wr_i),
    .refresh_busy_i (refresh_busy_i),
    .peer_active_i  (peer_active_i),
    .master_mode_i  (master_mode_i),
    .reason_o       (reason)
  );

  wsa_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr),
    .en_i  (en),
    .cnt_o (cnt)
  );

  wsa_ctrl #(.WR_WAITS(WR_WAITS), .TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start),
    .reason_i       (reason),
    .refresh_done_i (refresh_done_i),
    .ram_grant_i    (ram_grant_i),
    .bus_ack_i      (bus_ack_i),
    .cnt_i          (cnt),
    .clr_o          (clr),
    .en_o           (en),
    .busy_o         (busy),
    .err_o          (timeout_err_o)
  );

  assign ready_o = ~busy & ~(start & (reason != RSN_NONE));

  AST_FAST_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && tgt_i <= 3'd2) |-> ready_o); // R1
  AST_REFRESH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && tgt_i == 3'd3 && refresh_busy_i) |-> !ready_o); // R2
  AST_PEER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && tgt_i == 3'd3 && peer_active_i) |-> !ready_o); // R3
  AST_MASTER_OFFBOARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && master_mode_i && (tgt_i == 3'd4 || tgt_i == 3'd5)) |-> !ready_o); // R4
  AST_DRAM_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && tgt_i == 3'd3 && wr_i) |-> !ready_o); // R5
  AST_RESERVED_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && tgt_i >= 3'd6) |-> ready_o); // R11
  AST_RESET_READY: assert property (@(posedge clk)
    !rst_n |-> (ready_o && !timeout_err_o)); // R10
endmodule

// File: tb/sim_wsa_ready_gen.sv
module sim_wsa_ready_gen;
  localparam int WRW = 3;
  localparam int TO  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ale = 0, wr = 0, rbusy = 0, rdone = 0, peer = 0, grant = 0, master = 0, ack = 0;
  logic [2:0] tgt = '0;
  logic ready, err;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  wsa_ready_gen #(.WR_WAITS(WRW), .TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .ale_i(ale), .tgt_i(tgt), .wr_i(wr),
    .refresh_busy_i(rbusy), .refresh_done_i(rdone), .peer_active_i(peer),
    .ram_grant_i(grant), .master_mode_i(master), .bus_ack_i(ack),
    .ready_o(ready), .timeout_err_o(err));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model: number of ready-low cycles
  function automatic int exp_low(input int t, input bit w, input bit rb, input bit pa,
                                 input bit mm, input int dd, input int dg, input int da);
    if (t == 3) begin
      if (rb) return dd + 1;
      if (pa) return dg + 1;
      if (w)  return WRW;
      return 0;
    end
    if ((t == 4 || t == 5) && mm) begin
      if (da == 0 || da > TO) return TO + 1;
      return da + 1;
    end
    return 0;
  endfunction

  function automatic bit exp_err(input int t, input bit mm, input int da);
    return (t == 4 || t == 5) && mm && (da == 0 || da > TO);
  endfunction

  task automatic access(input int t, input bit w, input bit rb, input bit pa, input bit mm,
                        input int dd, input int dg, input int da, input string req);
    int low = 0;
    int el;
    el = exp_low(t, w, rb, pa, mm, dd, dg, da);
    @(negedge clk);
    tgt = 3'(t); wr = w; rbusy = rb; peer = pa; master = mm; ale = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      ale   = 1'b0;
      rdone = (c == dd);
      grant = (c == dg);
      ack   = (da != 0) && (c == da);
      #1;
      if (ready) break;
      low++;
    end
    check(low == el, req, low, el);
    if (el > 0) check(err == exp_err(t, mm, da), {req, " err"}, err, exp_err(t, mm, da));
    @(negedge clk);
    rdone = 0; grant = 0; ack = 0; rbusy = 0; peer = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a11));
    // R10 reset state
    #1;
    check(ready == 1'b1, "R10 reset ready", ready, 1);
    check(err == 1'b0, "R10 reset err", err, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 fast targets, also off-board without master mode
    access(0, 0, 1, 1, 1, 1, 1, 1, "R1 prom");
    access(1, 1, 1, 1, 1, 1, 1, 1, "R1 io");
    access(2, 1, 1, 1, 1, 1, 1, 1, "R1 sram");
    access(4, 1, 0, 0, 0, 1, 1, 0, "R1 offmem slave");
    access(6, 1, 1, 1, 1, 1, 1, 1, "R11 rsv6");
    access(7, 0, 1, 1, 1, 1, 1, 1, "R11 rsv7");
    // R2 / R3 / R4 / R5 directed
    access(3, 0, 1, 0, 0, 4, 0, 0, "R2 refresh");
    access(3, 0, 0, 1, 0, 0, 2, 0, "R3 peer");
    access(5, 0, 0, 0, 1, 0, 0, 3, "R4 offio ack");
    access(3, 1, 0, 0, 0, 0, 0, 0, "R5 dram write");
    access(3, 0, 0, 0, 0, 1, 1, 1, "R6 dram read no wait");
    // R9 priority: grant early during refresh wait has no effect
    access(3, 1, 1, 1, 0, 3, 1, 0, "R9 refresh over peer");
    access(3, 1, 0, 1, 0, 0, 1, 0, "R9 peer write no extra");
    // R7 timeout, then R8 ack on last cycle, then flag cleared
    access(4, 0, 0, 0, 1, 0, 0, 0, "R7 timeout");
    access(4, 0, 0, 0, 1, 0, 0, TO, "R8 ack at last cycle");
    access(5, 1, 0, 0, 1, 0, 0, TO + 1, "R7 ack too late");
    access(3, 1, 0, 0, 0, 0, 0, 0, "R7 flag cleared");
    // R6 stray strobes while idle do not pull ready low
    @(negedge clk);
    rdone = 1; grant = 1; ack = 1; rbusy = 1; peer = 1; master = 1; tgt = 3'd3; #1;
    check(ready == 1'b1, "R6 no start no wait", ready, 1);
    @(negedge clk);
    rdone = 0; grant = 0; ack = 0; rbusy = 0; peer = 0;
    // R10 reset in the middle of a wait
    @(negedge clk); tgt = 3'd3; rbusy = 1; ale = 1;
    @(negedge clk); ale = 0; #1;
    check(ready == 1'b0, "R2 wait before reset", ready, 0);
    @(negedge clk); rst_n = 1'b0; #1;
    check(ready == 1'b1, "R10 reset mid wait", ready, 1);
    @(negedge clk); rbusy = 0; rst_n = 1'b1;
    // random mix
    for (int i = 0; i < 400; i++) begin
      int t, dd, dg, da;
      t  = $urandom_range(7, 0);
      dd = $urandom_range(8, 1);
      dg = $urandom_range(8, 1);
      da = $urandom_range(TO + 2, 0);
      access(t, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             dd, dg, da, "R1-mix random R2 R3 R4 R5 R7 R8 R9");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule